// File: doc/BRIEF.md
# Waveform Sample Capture Unit

This block watches three phase streams of signed 24-bit current samples. All three streams arrive together on one valid strobe at a fixed base rate. The block picks one phase and thins the strobes by a chosen power of two. Each kept sample goes into a single holding register. An active-low interrupt tells the host that a fresh sample is ready. A mask bit gates that interrupt. The host clears it by reading the reset-status register.

The host fetches the held sample over a byte-wide read port. A read at the waveform address returns the most significant byte first. Each further byte request returns the next byte. While a three-byte read is in progress the holding register is frozen. A sample that arrives during the read waits in a one-deep pending slot and is committed as soon as the read ends. The block only taps the sample streams, so any processing running beside it is not disturbed.

Top module: `wfcap_top`

## Requirements
- R1: After synchronous reset, `irq_n` is 1, `rd_vld` is 0 and the holding register reads back as 0x000000.
- R2: `cfg_phase` selects the captured stream: 0 selects `smp_a`, 1 selects `smp_b` and 2 selects `smp_c`.
- R3: Samples are captured only while `cfg_src` equals 3'b000. With any other value, strobes change neither the holding register nor `irq_n`.
- R4: While `cfg_phase` is 3, no sample is captured and `irq_n` is not set.
- R5: A 3-bit counter counts every `smp_vld` strobe since reset, modulo 8. A strobe is kept only if the low `cfg_rate` bits of the count are zero before that strobe. Rate codes 0, 1, 2 and 3 therefore keep 1 strobe in 1, 2, 4 and 8.
- R6: At the clock edge that commits a sample, `irq_n` goes to 0 if `cfg_rdy_mask` is 1. If the mask is 0, the sample is still committed but `irq_n` does not change.
- R7: `irq_n` stays at 0 until a `status_rd` pulse. It returns to 1 at the next edge, unless a masked-in sample is committed at that same edge, in which case it stays at 0.
- R8: A `host_rd` at `host_addr` 0x12 while no read is open starts a read. The cycle after the request, `rd_vld` is 1 and `rd_data` holds bits 23:16. The next two `byte_req` pulses return bits 15:8 and then bits 7:0, each one cycle after its pulse. After the third byte the read closes. Any other address gives no response, and `rd_vld` is 0 in any cycle that follows no request.
- R9: From the starting request until the third byte is returned, the holding register does not change. A sample kept during this window is committed at the first edge after the read closes and raises the interrupt then. If several samples are kept during the window, only the newest is committed.
- R10: Samples are stored and returned bit-exact over the whole signed range, including the full-scale extremes 0xD7AE14 and 0x2851EC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Base-rate strobe that marks a new sample on all three phase buses |
| smp_a | input | 24 | Phase A sample, two's complement |
| smp_b | input | 24 | Phase B sample, two's complement |
| smp_c | input | 24 | Phase C sample, two's complement |
| cfg_src | input | 3 | Waveform source select; 000 selects current capture |
| cfg_phase | input | 2 | Phase select (0 = A, 1 = B, 2 = C, 3 = none) |
| cfg_rate | input | 2 | Decimation code: keep 1 strobe in 2^code |
| cfg_rdy_mask | input | 1 | Enables the sample-ready interrupt |
| status_rd | input | 1 | Pulse: host reads the reset-status register |
| host_rd | input | 1 | Pulse: register read request |
| host_addr | input | 8 | Register address for `host_rd` |
| byte_req | input | 1 | Pulse: request the next byte of an open read |
| irq_n | output | 1 | Sample-ready interrupt, active low |
| rd_vld | output | 1 | `rd_data` is valid this cycle |
| rd_data | output | 8 | Returned byte |

## Verification
Two collisions can fall in one clock. First, a status read and a new sample commit can land on the same edge; the bench pulses `status_rd` with a kept strobe while the interrupt is already low, and requires `irq_n` to stay low. Second, a kept strobe can arrive during an open byte read; the bench injects strobes between byte requests. It then requires that all three bytes belong to the old word, that `irq_n` stays high until the edge after the last byte, and that the next read returns the newest strobe. Random traffic mixes these collisions with rate and phase changes, and every cycle is compared against a model held in the bench.

// File: rtl/wfcap_pkg.sv
package wfcap_pkg;

    localparam int SMP_W   = 24;
    localparam int N_PH    = 3;
    localparam int CNT_W   = 3;
    localparam int RATE_W  = 2;
    localparam int SRC_W   = 3;
    localparam int PH_W    = 2;
    localparam int ADDR_W  = 8;
    localparam int BYTE_W  = 8;
    localparam int N_BYTES = SMP_W / BYTE_W;
    localparam int IDX_W   = 2;

    localparam logic [ADDR_W-1:0] WAVE_ADDR   = 8'h12;
    localparam logic [SRC_W-1:0]  SRC_CURRENT = '0;

    typedef logic [SMP_W-1:0] smp_t;

    typedef enum logic [PH_W-1:0] {
        PH_A    = 2'd0,
        PH_B    = 2'd1,
        PH_C    = 2'd2,
        PH_NONE = 2'd3
    } phase_e;

    // candidate sample leaving the selector
    typedef struct packed {
        logic keep;
        smp_t data;
    } pick_t;

    // one-deep slot for a sample that arrived during a read
    typedef struct packed {
        logic vld;
        smp_t data;
    } pend_t;

    // low 'r' bits set
    function automatic logic [CNT_W-1:0] rate_mask(input logic [RATE_W-1:0] r);
        logic [CNT_W-1:0] m;
        m = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i < int'(r)) m[i] = 1'b1;
        end
        return m;
    endfunction

    // byte i of a word, counted from the most significant end
    function automatic logic [BYTE_W-1:0] byte_sel(input smp_t w, input logic [IDX_W-1:0] i);
        logic [BYTE_W-1:0] b;
        b = '0;
        for (int k = 0; k < N_BYTES; k++) begin
            if (i == IDX_W'(k)) b = w[BYTE_W*(N_BYTES-1-k) +: BYTE_W];
        end
        return b;
    endfunction

endpackage

// File: rtl/wfcap_pick.sv
module wfcap_pick
    import wfcap_pkg::*;
#(
    parameter int NPH    = N_PH,
    parameter int SW     = SMP_W,
    parameter int CW     = CNT_W,
    parameter int RW     = RATE_W,
    parameter int SRCW   = SRC_W,
    parameter int PHW    = PH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [NPH*SW-1:0] smp_bus,
    input  logic [SRCW-1:0]   src,
    input  logic [PHW-1:0]    phase,
    input  logic [RW-1:0]     rate,
    output pick_t             pick
);

    logic [CW-1:0] cnt_q;
    smp_t          lane [NPH];
    logic          capture_on;
    logic          rate_hit;
    smp_t          lane_sel;

    for (genvar g = 0; g < NPH; g++) begin : g_lane
        assign lane[g] = smp_bus[g*SW +: SW];
    end

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (smp_vld) cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        lane_sel = '0;
        for (int i = 0; i < NPH; i++) begin
            if (phase == PHW'(i)) lane_sel = lane[i];
        end
    end

    assign capture_on = (src == SRC_CURRENT) && (phase_e'(phase) != PH_NONE);
    assign rate_hit   = (cnt_q & rate_mask(rate)) == '0;
    assign pick.keep  = smp_vld && capture_on && rate_hit;
    assign pick.data  = lane_sel;

    p_cnt_step_r5: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> cnt_q == $past(cnt_q) + 1'b1);
    p_cnt_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(cnt_q));

endmodule

// File: rtl/wfcap_hold.sv
module wfcap_hold
    import wfcap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pick_t pick,
    input  logic  reading,
    output smp_t  hold_q,
    output logic  commit
);

    pend_t pend_q;

    // a direct capture wins over an older pending sample
    assign commit = !reading && (pick.keep || pend_q.vld);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            pend_q <= '0;
        end else if (reading) begin
            if (pick.keep) begin
                pend_q.vld  <= 1'b1;
                pend_q.data <= pick.data;
            end
        end else begin
            if (pick.keep)      hold_q <= pick.data;
            else if (pend_q.vld) hold_q <= pend_q.data;
            pend_q.vld <= 1'b0;
        end
    end

    p_hold_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        reading |=> $stable(hold_q));
    p_pend_drain_r9: assert property (@(posedge clk) disable iff (rst)
        (pend_q.vld && !reading) |=> !pend_q.vld);
    p_no_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (!pick.keep && !pend_q.vld) |=> $stable(hold_q));

endmodule

// File: rtl/wfcap_irq.sv
module wfcap_irq (
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  logic mask,
    input  logic status_rd,
    output logic irq_n
);

    logic flag_q;
    logic set_req;

    assign set_req = commit && mask;

    always_ff @(posedge clk) begin
        if (rst)            flag_q <= 1'b0;
        else if (set_req)   flag_q <= 1'b1;
        else if (status_rd) flag_q <= 1'b0;
    end

    assign irq_n = ~flag_q;

    p_irq_set_r6: assert property (@(posedge clk) disable iff (rst)
        set_req |=> !irq_n);
    p_irq_clr_r7: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !set_req) |=> irq_n);
    p_irq_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (!set_req && !status_rd) |=> $stable(irq_n));

endmodule

// File: rtl/wfcap_rdport.sv
module wfcap_rdport
    import wfcap_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W,
    parameter int NB = N_BYTES,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_rd,
    input  logic [AW-1:0] host_addr,
    input  logic          byte_req,
    input  smp_t          hold,
    output logic          reading,
    output logic          rd_vld,
    output logic [BW-1:0] rd_data
);

    logic          busy_q;
    logic [IW-1:0] idx_q;
    logic          start;

    assign start   = host_rd && (host_addr == WAVE_ADDR) && !busy_q;
    assign reading = busy_q || start;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            idx_q   <= '0;
            rd_vld  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_vld <= 1'b0;
            if (start) begin
                busy_q  <= 1'b1;
                idx_q   <= IW'(1);
                rd_vld  <= 1'b1;
                rd_data <= byte_sel(hold, '0);
            end else if (busy_q && byte_req) begin
                rd_vld  <= 1'b1;
                rd_data <= byte_sel(hold, idx_q);
                if (idx_q == IW'(NB-1)) busy_q <= 1'b0;
                else                    idx_q  <= idx_q + 1'b1;
            end
        end
    end

    p_start_r8: assert property (@(posedge clk) disable iff (rst)
        start |=> (rd_vld && busy_q));
    p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!host_rd && !byte_req) |=> !rd_vld);
    p_idx_range_r8: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (int'(idx_q) < NB));

endmodule

// File: rtl/wfcap_top.sv
module wfcap_top
    import wfcap_pkg::*;
#(
    parameter int SW   = SMP_W,
    parameter int NPH  = N_PH,
    parameter int CW   = CNT_W,
    parameter int RW   = RATE_W,
    parameter int SRCW = SRC_W,
    parameter int PHW  = PH_W,
    parameter int AW   = ADDR_W,
    parameter int BW   = BYTE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            smp_vld,
    input  logic [SW-1:0]   smp_a,
    input  logic [SW-1:0]   smp_b,
    input  logic [SW-1:0]   smp_c,
    input  logic [SRCW-1:0] cfg_src,
    input  logic [PHW-1:0]  cfg_phase,
    input  logic [RW-1:0]   cfg_rate,
    input  logic            cfg_rdy_mask,
    input  logic            status_rd,
    input  logic            host_rd,
    input  logic [AW-1:0]   host_addr,
    input  logic            byte_req,
    output logic            irq_n,
    output logic            rd_vld,
    output logic [BW-1:0]   rd_data
);

    logic [NPH*SW-1:0] smp_bus;
    pick_t             pick;
    smp_t              hold;
    logic              reading;
    logic              commit;

    assign smp_bus = {smp_c, smp_b, smp_a};

    wfcap_pick #(
        .NPH(NPH), .SW(SW), .CW(CW), .RW(RW), .SRCW(SRCW), .PHW(PHW)
    ) u_pick (
        .clk     (clk),
        .rst     (rst),
        .smp_vld (smp_vld),
        .smp_bus (smp_bus),
        .src     (cfg_src),
        .phase   (cfg_phase),
        .rate    (cfg_rate),
        .pick    (pick)
    );

    wfcap_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .pick    (pick),
        .reading (reading),
        .hold_q  (hold),
        .commit  (commit)
    );

    wfcap_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .mask      (cfg_rdy_mask),
        .status_rd (status_rd),
        .irq_n     (irq_n)
    );

    wfcap_rdport #(
        .AW(AW), .BW(BW)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .host_rd   (host_rd),
        .host_addr (host_addr),
        .byte_req  (byte_req),
        .hold      (hold),
        .reading   (reading),
        .rd_vld    (rd_vld),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/tb_wfcap_top.sv
`timescale 1ns/1ps
module tb_wfcap_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_vld = 1'b0;
    logic [23:0] smp_a = '0, smp_b = '0, smp_c = '0;
    logic [2:0]  cfg_src = '0;
    logic [1:0]  cfg_phase = '0;
    logic [1:0]  cfg_rate = '0;
    logic        cfg_rdy_mask = 1'b1;
    logic        status_rd = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_addr = 8'h12;
    logic        byte_req = 1'b0;
    logic        irq_n;
    logic        rd_vld;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [2:0]  m_cnt;
    logic [23:0] m_hold, m_pend;
    logic        m_pv, m_flag, m_busy, m_rdv;
    int          m_idx;
    logic [7:0]  m_rdd;

    wfcap_top dut (
        .clk(clk), .rst(rst), .smp_vld(smp_vld),
        .smp_a(smp_a), .smp_b(smp_b), .smp_c(smp_c),
        .cfg_src(cfg_src), .cfg_phase(cfg_phase), .cfg_rate(cfg_rate),
        .cfg_rdy_mask(cfg_rdy_mask), .status_rd(status_rd),
        .host_rd(host_rd), .host_addr(host_addr), .byte_req(byte_req),
        .irq_n(irq_n), .rd_vld(rd_vld), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] byte_of(logic [23:0] w, int i);
        return w[8*(2-i) +: 8];
    endfunction

    function automatic logic [23:0] lane_of(int ph);
        return (ph == 0) ? smp_a : (ph == 1) ? smp_b : smp_c;
    endfunction

    task automatic model_step();
        logic        start, reading, keep, commit;
        logic [23:0] old_hold;
        if (rst) begin
            m_cnt = '0; m_hold = '0; m_pend = '0; m_pv = 0;
            m_flag = 0; m_busy = 0; m_idx = 0; m_rdv = 0; m_rdd = '0;
            return;
        end
        old_hold = m_hold;
        start   = host_rd && host_addr == 8'h12 && !m_busy;
        reading = m_busy || start;
        keep    = smp_vld && cfg_src == 3'd0 && cfg_phase != 2'd3 &&
                  ((int'(m_cnt) % (1 << cfg_rate)) == 0);
        commit  = 0;
        if (keep && !reading) begin
            m_hold = lane_of(int'(cfg_phase)); m_pv = 0; commit = 1;
        end else if (keep) begin
            m_pend = lane_of(int'(cfg_phase)); m_pv = 1;
        end else if (m_pv && !reading) begin
            m_hold = m_pend; m_pv = 0; commit = 1;
        end
        if (smp_vld) m_cnt = m_cnt + 3'd1;
        if (commit && cfg_rdy_mask) m_flag = 1;
        else if (status_rd)         m_flag = 0;
        m_rdv = 0;
        if (start) begin
            m_busy = 1; m_idx = 1; m_rdv = 1; m_rdd = byte_of(old_hold, 0);
        end else if (m_busy && byte_req) begin
            m_rdv = 1; m_rdd = byte_of(old_hold, m_idx);
            if (m_idx == 2) m_busy = 0; else m_idx++;
        end
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // one clock: DUT and model see the same inputs, outputs compared after the edge
    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        #1;
        chk(tag, "irq_n vs model", int'(irq_n), int'(!m_flag));
        chk(tag, "rd_vld vs model", int'(rd_vld), int'(m_rdv));
        if (m_rdv) chk(tag, "rd_data vs model", int'(rd_data), int'(m_rdd));
        smp_vld = 0; status_rd = 0; host_rd = 0; byte_req = 0; host_addr = 8'h12;
    endtask

    task automatic push(logic [23:0] a, logic [23:0] b, logic [23:0] c, string tag);
        smp_vld = 1; smp_a = a; smp_b = b; smp_c = c;
        tick(tag);
    endtask

    task automatic read_word(string tag, output logic [23:0] w);
        host_rd = 1; host_addr = 8'h12;
        tick(tag); w[23:16] = rd_data;
        byte_req = 1;
        tick(tag); w[15:8] = rd_data;
        byte_req = 1;
        tick(tag); w[7:0] = rd_data;
    endtask

    task automatic clr_irq();
        status_rd = 1;
        tick("R7");
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] w;
        int          seen, seed;
        seed = 32'h5eed;
        void'($urandom(seed));

        // R1: reset state
        rst = 1;
        tick("R1"); tick("R1"); tick("R1");
        chk("R1", "irq_n in reset", int'(irq_n), 1);
        chk("R1", "rd_vld in reset", int'(rd_vld), 0);
        rst = 0;
        tick("R1");
        read_word("R1", w);
        chk("R1", "hold after reset", int'(w), 0);

        // R2: phase routing, R6/R7 interrupt set and clear
        for (int ph = 0; ph < 3; ph++) begin
            cfg_phase = 2'(ph);
            push(24'h111111, 24'h222222, 24'h333333, "R2");
            chk("R6", "irq_n after commit", int'(irq_n), 0);
            clr_irq();
            chk("R7", "irq_n after status read", int'(irq_n), 1);
            read_word("R2", w);
            chk("R2", "captured lane", int'(w), int'(24'h111111 * (ph + 1)));
        end

        // R10: full-scale extremes
        cfg_phase = 2'd0;
        push(24'hD7AE14, 24'h0, 24'h0, "R10");
        clr_irq();
        read_word("R10", w);
        chk("R10", "negative full scale", int'(w), int'(24'hD7AE14));
        push(24'h2851EC, 24'h0, 24'h0, "R10");
        clr_irq();
        read_word("R10", w);
        chk("R10", "positive full scale", int'(w), int'(24'h2851EC));

        // R3: source not current
        cfg_src = 3'b010;
        push(24'hABCDEF, 24'hABCDEF, 24'hABCDEF, "R3");
        chk("R3", "irq_n with other source", int'(irq_n), 1);
        read_word("R3", w);
        chk("R3", "hold with other source", int'(w), int'(24'h2851EC));
        cfg_src = 3'b000;

        // R4: phase 3
        cfg_phase = 2'd3;
        push(24'h123456, 24'h123456, 24'h123456, "R4");
        chk("R4", "irq_n with phase 3", int'(irq_n), 1);
        read_word("R4", w);
        chk("R4", "hold with phase 3", int'(w), int'(24'h2851EC));
        cfg_phase = 2'd0;

        // R6: mask off
        cfg_rdy_mask = 0;
        push(24'h0F0F0F, 24'h0, 24'h0, "R6");
        chk("R6", "irq_n masked", int'(irq_n), 1);
        read_word("R6", w);
        chk("R6", "masked sample still held", int'(w), int'(24'h0F0F0F));
        cfg_rdy_mask = 1;

        // R5: decimation ratio over 16 strobes
        for (int r = 0; r < 4; r++) begin
            cfg_rate = 2'(r);
            seen = 0;
            for (int k = 0; k < 16; k++) begin
                push(24'(k), 24'h0, 24'h0, "R5");
                if (irq_n == 1'b0) seen++;
                clr_irq();
            end
            chk("R5", "kept strobes per 16", seen, 16 >> r);
        end
        cfg_rate = 2'd0;

        // R7: status read and new commit on the same edge
        push(24'h00AA00, 24'h0, 24'h0, "R7");
        status_rd = 1;
        push(24'h00BB00, 24'h0, 24'h0, "R7");
        chk("R7", "irq_n on collision", int'(irq_n), 0);
        clr_irq();
        chk("R7", "irq_n after later clear", int'(irq_n), 1);

        // R9: samples arriving during a read
        host_rd = 1; tick("R9");
        chk("R9", "first byte of old word", int'(rd_data), 8'h00);
        byte_req = 1;
        push(24'hC0FFEE, 24'h0, 24'h0, "R9");
        push(24'hBEEF01, 24'h0, 24'h0, "R9");
        chk("R9", "irq_n during read", int'(irq_n), 1);
        byte_req = 1; tick("R9");
        chk("R9", "last byte of old word", int'(rd_data), 8'h00);
        chk("R9", "irq_n right after read", int'(irq_n), 1);
        tick("R9");
        chk("R9", "irq_n after drain", int'(irq_n), 0);
        clr_irq();
        read_word("R9", w);
        chk("R9", "newest pending sample", int'(w), int'(24'hBEEF01));

        // R8: other address, stray byte request
        host_rd = 1; host_addr = 8'h13; tick("R8");
        chk("R8", "rd_vld for other address", int'(rd_vld), 0);
        byte_req = 1; tick("R8");
        chk("R8", "rd_vld for stray byte_req", int'(rd_vld), 0);
        read_word("R8", w);
        chk("R8", "word after ignored requests", int'(w), int'(24'hBEEF01));

        // random traffic against the model (R5 R7 R8 R9)
        for (int c = 0; c < 3000; c++) begin
            smp_vld = ($urandom % 3) == 0;
            smp_a = 24'($urandom); smp_b = 24'($urandom); smp_c = 24'($urandom);
            if ($urandom % 40 == 0) cfg_src = ($urandom % 4 == 0) ? 3'($urandom) : 3'd0;
            if ($urandom % 30 == 0) cfg_phase = 2'($urandom);
            if ($urandom % 50 == 0) cfg_rate = 2'($urandom);
            cfg_rdy_mask = ($urandom % 10) != 0;
            status_rd = ($urandom % 7) == 0;
            host_rd = ($urandom % 9) == 0;
            host_addr = ($urandom % 5 == 0) ? 8'h20 : 8'h12;
            byte_req = ($urandom % 3) == 0;
            tick("R5 R7 R8 R9 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule